// File: doc/BRIEF.md
# Freeze-Gated Shadow Control Register Bank

This block is the control register bank of an audio codec. A simple synchronous register bus writes and reads it. The bus has an address, write data, a write strobe and combinational read data. One part of the register space drives the audio datapath through a shadow stage. These are the eight volume registers, the channel-invert register and four mixing registers. Each has a staged (shadow) copy and a live (active) copy. A hold bit in the miscellaneous control register decides when staged values reach the live copies.

While the hold bit is clear, a write to a gated register reaches its live output at once. While the hold bit is set, such writes change only the staged copy, and the live outputs keep their old values. Clearing the hold bit releases every staged value to the live outputs in one clock edge. Software can therefore change several gains and mix settings together. The miscellaneous control register is never held back.

Top module: `fz_shadow_regs`

## Requirements
- R1: After reset, every output is 0, and a read of any address returns 0.
- R2: A write to address 05h shows on the misc pins on the clock edge that takes the write. The field positions are: bit 0 selects the audio-port master, bit 1 selects the codec-port master, bit 2 holds the high-pass filter, bit 3 is the filter select, bit 4 is the hold (freeze) bit, bit 6 enables the master clock tri-state, and bit 7 selects the ADC serial clock. This holds whether or not the hold bit is set.
- R3: While the hold bit is 1, no gated live output changes, although writes to gated addresses are accepted.
- R4: Suppose a write to 05h changes the hold bit from 1 to 0. Then on the next clock edge, every gated live output takes its staged value, and all of them change on that same edge.
- R5: While the hold bit is 0, a write to a gated address updates that register's live output on the same edge. Gated address 0Fh+i drives slice `gated_q[8*i +: 8]` for i = 0..12: 0Fh..16h are the volume registers, 17h is the invert register and 18h..1Bh are the mixing registers.
- R6: A read of a gated address returns its staged value, which is the value most recently written.
- R7: Bit 5 of 05h ignores writes and always reads 0.
- R8: A read of any address other than 05h and 0Fh..1Bh returns 0. A write to such an address changes neither any output nor any read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| adc_sclk_sel | output | 1 | ADC serial clock source select |
| rmck_hiz | output | 1 | Master clock tri-state request |
| hold_on | output | 1 | Current hold (freeze) bit |
| filt_sel | output | 1 | Filter select |
| hpf_hold | output | 1 | High-pass filter hold |
| codec_master | output | 1 | Codec port master select |
| sai_master | output | 1 | Audio port master select |
| gated_q | output | 104 | Live values of the 13 gated registers |

## Verification
The hardest case to reach is the release edge. Staged values sit in shadow storage while the live outputs still show old data, and a single write to 05h must move all thirteen values at once, one clock later. The stimulus sets the hold bit and then writes a distinct value to every gated address. It reads each one back to confirm it is staged. It then clears the hold bit and samples the live bus twice: once in the cycle the write is taken, where every value must still be old, and once a cycle later, where every value must be new.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int DW         = 8;
  localparam int AW         = 8;
  localparam int MISC_ADDR  = 'h05;
  localparam int GATE_BASE  = 'h0F;
  localparam int GATE_COUNT = 13;
  localparam int HOLD_BIT   = 4;
  localparam int RSV_BIT    = 5;
  localparam logic [DW-1:0] MISC_WMASK = ~(DW'(1) << RSV_BIT);
endpackage

// File: rtl/fz_misc_reg.sv
module fz_misc_reg
  import fz_pkg::*;
#(
  parameter int ADDR = MISC_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic hit;
  assign hit = we && (addr == AW'(ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (hit) q <= wdata & MISC_WMASK;
  end

  assert_misc_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> q == ($past(wdata) & MISC_WMASK));
  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q[RSV_BIT] == 1'b0);
endmodule

// File: rtl/fz_release_detect.sv
module fz_release_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic commit
);
  logic hold_d;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_d <= 1'b0;
    else        hold_d <= hold;
  end

  assign commit = hold_d & ~hold;

  assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/fz_gated_slot.sv
module fz_gated_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         hold,
  input  logic         commit,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr) shadow <= wdata;
      if (wr && !hold) active <= wdata;
      else if (commit) active <= shadow;
    end
  end

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(active));
  assert_commit_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr) |=> active == $past(shadow));
  assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hold) |=> active == $past(wdata));
  assert_stage_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> shadow == $past(wdata));
endmodule

// File: rtl/fz_shadow_regs.sv
module fz_shadow_regs
  import fz_pkg::*;
#(
  parameter int NG   = GATE_COUNT,
  parameter int BASE = GATE_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_we,
  output logic [DW-1:0]    reg_rdata,
  output logic             adc_sclk_sel,
  output logic             rmck_hiz,
  output logic             hold_on,
  output logic             filt_sel,
  output logic             hpf_hold,
  output logic             codec_master,
  output logic             sai_master,
  output logic [NG*DW-1:0] gated_q
);
  logic [DW-1:0] misc_q;
  logic          commit;
  logic [DW-1:0] shadow [NG];

  fz_misc_reg #(.ADDR(MISC_ADDR)) u_misc (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .q(misc_q)
  );

  fz_release_detect u_rel (
    .clk(clk), .rst_n(rst_n), .hold(misc_q[HOLD_BIT]), .commit(commit)
  );

  for (genvar i = 0; i < NG; i++) begin : g_slot
    logic wr_i;
    assign wr_i = reg_we && (reg_addr == AW'(BASE + i));
    fz_gated_slot #(.W(DW)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr(wr_i), .wdata(reg_wdata),
      .hold(misc_q[HOLD_BIT]), .commit(commit),
      .shadow(shadow[i]), .active(gated_q[i*DW +: DW])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(MISC_ADDR)) reg_rdata = misc_q;
    for (int i = 0; i < NG; i++)
      if (reg_addr == AW'(BASE + i)) reg_rdata = shadow[i];
  end

  assign sai_master   = misc_q[0];
  assign codec_master = misc_q[1];
  assign hpf_hold     = misc_q[2];
  assign filt_sel     = misc_q[3];
  assign hold_on      = misc_q[HOLD_BIT];
  assign rmck_hiz     = misc_q[6];
  assign adc_sclk_sel = misc_q[7];

  assert_hold_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(MISC_ADDR)) |=> hold_on == $past(reg_wdata[HOLD_BIT]));
endmodule

// File: tb/fz_shadow_regs_bench.sv
module fz_shadow_regs_bench;
  localparam int CLK_NS = 10;
  localparam int NG = 13;

  typedef struct { logic [7:0] val; string req; } exp_t;

  logic          clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0]    reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic          adc_sclk_sel, rmck_hiz, hold_on, filt_sel, hpf_hold, codec_master, sai_master;
  logic [NG*8-1:0] gated_q;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t sb[$];
  event rd_ev;
  logic [7:0] model [NG];

  fz_shadow_regs u_fz_shadow_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .adc_sclk_sel(adc_sclk_sel),
    .rmck_hiz(rmck_hiz), .hold_on(hold_on), .filt_sel(filt_sel),
    .hpf_hold(hpf_hold), .codec_master(codec_master), .sai_master(sai_master),
    .gated_q(gated_q)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    exp_t e;
    reg_addr = a;
    e.val = exp; e.req = req;
    sb.push_back(e);
    -> rd_ev;
    #2;
  endtask

  task automatic check_gated(input string req);
    for (int i = 0; i < NG; i++) check(gated_q[i*8 +: 8], model[i], req);
  endtask

  task automatic check_misc(input logic [7:0] v, input string req);
    check({adc_sclk_sel, rmck_hiz, 1'b0, hold_on, filt_sel, hpf_hold, codec_master, sai_master}, v, req);
  endtask

  // monitor: pops expected read data and compares
  initial forever begin
    exp_t e;
    @(rd_ev);
    #1;
    e = sb.pop_front();
    check(reg_rdata, e.val, e.req);
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NG; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_misc(8'h00, "R1");
    check_gated("R1");
    rd(8'h05, 8'h00, "R1");
    rd(8'h12, 8'h00, "R1");

    // R2 and R7: misc writes with hold clear
    wr(8'h05, 8'hEF);
    check_misc(8'hCF, "R2");
    rd(8'h05, 8'hCF, "R7");
    wr(8'h05, 8'h20);
    check_misc(8'h00, "R7");
    rd(8'h05, 8'h00, "R7");

    // R5: direct gated write
    wr(8'h0F, 8'h11); model[0] = 8'h11;
    check_gated("R5");

    // R3: set hold and stage every gated register
    wr(8'h05, 8'h10);
    check_misc(8'h10, "R2");
    for (int i = 0; i < NG; i++) begin
      wr(8'(8'h0F + i), 8'(8'h40 + i));
      check_gated("R3");
    end
    for (int i = 0; i < NG; i++) rd(8'(8'h0F + i), 8'(8'h40 + i), "R6");
    // R2: misc live while held
    wr(8'h05, 8'h13);
    check_misc(8'h13, "R2");
    check_gated("R3");

    // R4: release
    wr(8'h05, 8'h00);
    check_gated("R4");
    @(negedge clk);
    for (int i = 0; i < NG; i++) model[i] = 8'(8'h40 + i);
    check_gated("R4");

    // R8: unmapped space
    wr(8'h30, 8'h55);
    rd(8'h30, 8'h00, "R8");
    rd(8'h0E, 8'h00, "R8");
    rd(8'h1C, 8'h00, "R8");
    check_gated("R8");
    check_misc(8'h00, "R8");

    // R5: direct write to invert register after release
    wr(8'h17, 8'hA5); model[8] = 8'hA5;
    check_gated("R5");
    rd(8'h17, 8'hA5, "R6");

    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule